// File: doc/BRIEF.md
# Prescaled Up/Up-Down Timer Counter

This block is the time base of a timer/PWM unit. A 16-bit counter runs from zero towards a programmable terminal value. In up mode it wraps back to zero after the terminal value. In up-down mode it climbs to the terminal value and then descends to zero again, which is the sawtooth-free triangle needed for center-aligned PWM. Neighbouring channel logic reads the current count and the direction flag from it.

Counting is driven by one of two sources: the core clock itself, or rising edges of an asynchronous external input. The external input is synchronized first, and its edges are found by comparing consecutive synchronized samples. A selector can also stop the counter altogether. Between the source and the counter sits a power-of-two divider. A sticky overflow flag marks the end of each counter period, is cleared by a write-one-to-clear strobe, and drives an interrupt output when enabled. All configuration arrives on plain level inputs, and no handshake is involved.

Top module: `tmr_counter`

## Requirements
- R1: After reset `count_o` is 0, `dir_down_o` is 0, and both `ovf_flag_o` and `ovf_irq_o` are 0.
- R2: `cfg_clk_sel` 2'b01 selects the core clock, so that with `cfg_prescale` 0 the count advances on every clock edge. The values 2'b00 and 2'b11 stop the counter, and the count then holds its value.
- R3: With `cfg_clk_sel` 2'b10 the counter advances once per rising edge of `ext_clk_in`. The count changes at the third clock edge that samples the input high. An input held high or held low does not advance the counter.
- R4: `cfg_prescale` value p makes the counter advance once every 2^p source pulses, for p from 0 to 7.
- R5: In any cycle where `cfg_prescale` differs from its value in the previous cycle, the divider restarts and no count occurs. The next count follows a full 2^p source pulses later.
- R6: With `cfg_updown` 0 the counter steps up by one and goes to 0 on a count at or above `cfg_modulo`. That wrap sets `ovf_flag_o`, and `dir_down_o` stays 0.
- R7: With `cfg_updown` 1 the counter climbs to `cfg_modulo` and then descends. `dir_down_o` is 1 while descending. Arriving at 0 sets `ovf_flag_o` and turns the counter upward again. With `cfg_modulo` 0 the count stays at 0 and the flag is set on every count.
- R8: `ovf_flag_o` stays set until an `ovf_clear` pulse. A clear in the same cycle as a new overflow leaves the flag set.
- R9: `ovf_irq_o` is 1 exactly when `ovf_flag_o` is 1 and `cfg_ovf_ie` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clk_sel | input | 2 | Count source: 00 off, 01 core clock, 10 external edges, 11 off |
| cfg_prescale | input | 3 | Divider exponent p, divide by 2^p |
| cfg_updown | input | 1 | 0 up-only, 1 up-down |
| cfg_modulo | input | 16 | Terminal count value |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_clear | input | 1 | Write-one-to-clear strobe for the overflow flag |
| ext_clk_in | input | 1 | Asynchronous external count input |
| count_o | output | 16 | Current count |
| dir_down_o | output | 1 | 1 while counting down |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that configuration inputs are held steady relative to the clock. They also assume that the count never starts a descent from outside zero unless the block itself turned it downward. The stimulus changes settings only between clock edges and enters up-down mode only while the direction flag is clear. The external input is driven at clock-aligned times with high and low phases of at least one cycle, so the synchronizer sees each level. The stimulus also lowers the modulo value below the running count and clears the flag exactly on a wrap. These cases exercise the bounded-step and flag-retention properties at their edges.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    CK_OFF  = 2'b00,
    CK_CORE = 2'b01,
    CK_EXT  = 2'b10,
    CK_OFF2 = 2'b11
  } clk_sel_e;
endpackage

// File: rtl/tmr_ext_sync.sv
`timescale 1ns/1ps
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_in;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_pulse,
  input  logic [PS_W-1:0] ps_sel,
  output logic            tick_o
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [PS_W-1:0]  ps_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] last_val;
  logic             ps_changed;

  assign span       = (DIV_W+1)'(1) << ps_sel;
  assign last_val   = DIV_W'(span - 1'b1);
  assign ps_changed = (ps_sel != ps_q);
  assign tick_o     = src_pulse & ~ps_changed & (div_q == last_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      ps_q  <= '0;
    end else begin
      ps_q <= ps_sel;
      if (ps_changed)     div_q <= '0;
      else if (tick_o)    div_q <= '0;
      else if (src_pulse) div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             updown,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] count_o,
  output logic             down_o,
  output logic             ovf_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             down_q;
  logic [CNT_W-1:0] cnt_d;
  logic             down_d;
  logic             evt;
  logic [CNT_W-1:0] dec;

  assign dec = cnt_q - 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = updown ? down_q : 1'b0;
    evt    = 1'b0;
    if (tick) begin
      if (!updown) begin
        if (cnt_q >= modulo) begin
          cnt_d = '0;
          evt   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (down_q) begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d  = '0;
          down_d = 1'b0;
          evt    = 1'b1;
        end else begin
          cnt_d = dec;
        end
      end else if (cnt_q >= modulo) begin
        if (modulo == '0 || cnt_q == '0) begin
          cnt_d  = '0;
          down_d = 1'b0;
          evt    = 1'b1;
        end else if (dec == '0) begin
          cnt_d  = '0;
          down_d = 1'b0;
          evt    = 1'b1;
        end else begin
          cnt_d  = dec;
          down_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign count_o   = cnt_q;
  assign down_o    = down_q;
  assign ovf_evt_o = evt;
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W     = 16,
  parameter int PS_W      = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_clk_sel,
  input  logic [PS_W-1:0]  cfg_prescale,
  input  logic             cfg_updown,
  input  logic [CNT_W-1:0] cfg_modulo,
  input  logic             cfg_ovf_ie,
  input  logic             ovf_clear,
  input  logic             ext_clk_in,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             ovf_flag_o,
  output logic             ovf_irq_o
);
  import tmr_pkg::*;

  clk_sel_e sel;
  logic     ext_rise;
  logic     src_pulse;
  logic     tick;
  logic     ovf_evt;
  logic     flag_q;

  assign sel = clk_sel_e'(cfg_clk_sel);

  tmr_ext_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in), .rise_o(ext_rise)
  );

  always_comb begin
    case (sel)
      CK_CORE: src_pulse = 1'b1;
      CK_EXT:  src_pulse = ext_rise;
      default: src_pulse = 1'b0;
    endcase
  end

  tmr_prescaler #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .ps_sel(cfg_prescale), .tick_o(tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .updown(cfg_updown),
    .modulo(cfg_modulo), .count_o(count_o), .down_o(dir_down_o),
    .ovf_evt_o(ovf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (ovf_evt)   flag_q <= 1'b1;
    else if (ovf_clear) flag_q <= 1'b0;
  end

  assign ovf_flag_o = flag_q;
  assign ovf_irq_o  = flag_q & cfg_ovf_ie;
endmodule

// File: rtl/tmr_counter_chk.sv
`timescale 1ns/1ps
module tmr_counter_chk #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_clk_sel,
  input logic [PS_W-1:0]  cfg_prescale,
  input logic             cfg_updown,
  input logic             cfg_ovf_ie,
  input logic             ovf_clear,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_down_o,
  input logic             ovf_flag_o,
  input logic             ovf_irq_o
);
  // R2: a stopped source leaves the count untouched
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_sel == 2'b00 || cfg_clk_sel == 2'b11) |=> $stable(count_o));

  // R5: a prescaler change blocks the count in that cycle
  a_r5_change_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_prescale != $past(cfg_prescale)) |=> $stable(count_o));

  // R6: up-only mode moves by at most one step or wraps to zero
  a_r6_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_updown |=> (count_o == $past(count_o) ||
                     count_o == $past(count_o) + 1'b1 || count_o == '0));

  // R6: up-only mode never reports descending
  a_r6_no_down: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_updown |=> !dir_down_o);

  // R7: at zero the counter is always heading up
  a_r7_zero_is_up: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0) |-> !dir_down_o);

  // R8: flag is retained without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !ovf_clear) |=> ovf_flag_o);

  // R9: interrupt follows the enabled flag
  a_r9_irq_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag_o) && cfg_ovf_ie) |-> ovf_irq_o);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ovf_ie |-> !ovf_irq_o);
endmodule

bind tmr_counter tmr_counter_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_clk_sel(cfg_clk_sel),
  .cfg_prescale(cfg_prescale), .cfg_updown(cfg_updown),
  .cfg_ovf_ie(cfg_ovf_ie), .ovf_clear(ovf_clear), .count_o(count_o),
  .dir_down_o(dir_down_o), .ovf_flag_o(ovf_flag_o), .ovf_irq_o(ovf_irq_o)
);

// File: tb/tmr_counter_tb_top.sv
`timescale 1ns/1ps
module tmr_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_clk_sel = 2'b00;
  logic [2:0]  cfg_prescale = 3'd0;
  logic        cfg_updown = 1'b0;
  logic [15:0] cfg_modulo = 16'd5;
  logic        cfg_ovf_ie = 1'b0;
  logic        ovf_clear = 1'b0;
  logic        ext_clk_in = 1'b0;
  logic [15:0] count_o;
  logic        dir_down_o;
  logic        ovf_flag_o;
  logic        ovf_irq_o;

  always #2.5 clk = ~clk;

  tmr_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_clk_sel(cfg_clk_sel),
    .cfg_prescale(cfg_prescale), .cfg_updown(cfg_updown),
    .cfg_modulo(cfg_modulo), .cfg_ovf_ie(cfg_ovf_ie), .ovf_clear(ovf_clear),
    .ext_clk_in(ext_clk_in), .count_o(count_o), .dir_down_o(dir_down_o),
    .ovf_flag_o(ovf_flag_o), .ovf_irq_o(ovf_irq_o)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  int m_cnt, m_div, m_psq;
  bit m_dir, m_flag, m_s1, m_s2, m_s3;

  always @(posedge clk) begin
    bit rise, src, tk, ev;
    int span;
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_psq = 0;
      m_dir = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      rise = m_s2 && !m_s3;
      src  = (cfg_clk_sel == 2'b01) || (cfg_clk_sel == 2'b10 && rise);
      span = 1 << cfg_prescale;
      tk = 0;
      if (int'(cfg_prescale) != m_psq) m_div = 0;
      else if (src) begin
        m_div = m_div + 1;
        if (m_div == span) begin tk = 1; m_div = 0; end
      end
      m_psq = int'(cfg_prescale);
      ev = 0;
      if (!cfg_updown) begin
        m_dir = 0;
        if (tk) begin
          if (m_cnt >= int'(cfg_modulo)) begin m_cnt = 0; ev = 1; end
          else m_cnt = m_cnt + 1;
        end
      end else if (tk) begin
        if (m_dir) begin
          m_cnt = m_cnt - 1;
          if (m_cnt <= 0) begin m_cnt = 0; m_dir = 0; ev = 1; end
        end else if (m_cnt >= int'(cfg_modulo)) begin
          m_cnt = m_cnt - 1;
          if (m_cnt <= 0) begin m_cnt = 0; ev = 1; end
          else m_dir = 1;
        end else m_cnt = m_cnt + 1;
      end
      if (ev) m_flag = 1;
      else if (ovf_clear) m_flag = 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_in;
    end
  end

  task automatic step();
    @(negedge clk);
    checks++;
    if (int'(count_o) != m_cnt || dir_down_o !== m_dir || ovf_flag_o !== m_flag ||
        ovf_irq_o !== (m_flag && cfg_ovf_ie)) begin
      fails++;
      $display("FAIL %s t=%0t actual cnt=%0d dir=%0b flag=%0b irq=%0b expected cnt=%0d dir=%0b flag=%0b irq=%0b",
               cur_req, $time, count_o, dir_down_o, ovf_flag_o, ovf_irq_o,
               m_cnt, m_dir, m_flag, m_flag && cfg_ovf_ie);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired in %s actual=running expected=finished", cur_req);
      finish_run();
    end
  end

  initial begin
    cur_req = "R1";
    run(3);
    rst_n = 1'b1;
    run(2);

    cur_req = "R2"; cfg_clk_sel = 2'b01; cfg_modulo = 16'd7;
    run(5);
    cur_req = "R6"; cfg_ovf_ie = 1'b1;
    run(20);
    cur_req = "R9"; cfg_ovf_ie = 1'b0; run(3); cfg_ovf_ie = 1'b1; run(2);

    cur_req = "R8";
    ovf_clear = 1'b1; step(); ovf_clear = 1'b0; run(3);
    ovf_clear = 1'b1; run(12); ovf_clear = 1'b0; run(4);

    cur_req = "R2"; cfg_clk_sel = 2'b00; run(8);
    cfg_clk_sel = 2'b11; run(8); cfg_clk_sel = 2'b01; run(3);

    cur_req = "R4"; cfg_modulo = 16'd200; cfg_prescale = 3'd2; run(40);
    cfg_prescale = 3'd7; run(300);
    cur_req = "R5"; cfg_prescale = 3'd3; run(5);
    cfg_prescale = 3'd1; run(3); cfg_prescale = 3'd2; run(20);
    cfg_prescale = 3'd0; run(4);

    cur_req = "R6"; cfg_modulo = 16'd3; run(10);
    cfg_modulo = 16'd0; run(4);

    cur_req = "R7"; cfg_modulo = 16'd0; run(2);
    cfg_updown = 1'b1; run(6);
    cfg_modulo = 16'd4; run(30);
    cfg_modulo = 16'd1; run(10);
    cfg_modulo = 16'd6; cfg_prescale = 3'd1; run(60);
    cfg_prescale = 3'd0; run(3);
    while (dir_down_o) step();
    cfg_updown = 1'b0; cfg_modulo = 16'd9; run(12);

    cur_req = "R3"; cfg_clk_sel = 2'b10; run(4);
    for (int k = 1; k <= 4; k++) begin
      ext_clk_in = 1'b1; run(k);
      ext_clk_in = 1'b0; run(k + 1);
    end
    ext_clk_in = 1'b1; run(15); ext_clk_in = 1'b0; run(15);
    for (int k = 0; k < 6; k++) begin
      ext_clk_in = 1'b1; run(2); ext_clk_in = 1'b0; run(3);
    end
    cur_req = "R4"; cfg_prescale = 3'd1; run(2);
    for (int k = 0; k < 8; k++) begin
      ext_clk_in = 1'b1; run(1); ext_clk_in = 1'b0; run(2);
    end
    run(5);
    cur_req = "R1"; rst_n = 1'b0; run(2); rst_n = 1'b1; cfg_clk_sel = 2'b00; run(2);

    done = 1;
    finish_run();
  end
endmodule